// File: doc/BRIEF.md
# Thermal Throttle Clock Modulation Controller

This block produces a clock-enable pattern that throttles a core when the chip runs hot or when software asks it to. A modulation period is eight slots, each `SLOT_CLKS` clocks long. While throttling, the enable output is high for the first N slots of every period and low for the rest. Software sets N through a control register. A synchronized thermal-trip input can force a fixed automatic duty instead, when automatic mode is enabled.

The block also drives an active-low hot indicator that follows the synchronized trip input. It keeps a two-bit sticky interrupt status, with one bit for each edge of the hot condition. Software clears the status by writing 1s to it. A separate catastrophic over-temperature input sets an active-low shutdown output, which stays asserted until reset. The analog sensor, the clock gating cell and the power sequencing are outside this block.

Register writes use a single write strobe with a one-bit address. Address 0 is the control register. Address 1 is the interrupt status (write 1 to clear). Reset is synchronous and active high.

Top module: `thermal_throttle_ctl`

## Requirements
- R1: After reset, clk_en=1, hot_n=1, shutdown_n=1, irq=0 and irq_status=0, and every control field is 0.
- R2: Writing control bit 4 (software throttle request) as 1 starts throttling from the idle state, whatever the temperature input is. A new modulation period begins on the clock edge after the write edge.
- R3: While throttling, clk_en is high for the first N of the 8 slots in each period and low for the remaining slots. Each slot lasts SLOT_CLKS clocks. In software mode N is control bits 3:1; codes 1 to 7 give 1 to 7 slots, and code 0 gives 4 slots.
- R4: When control bit 5 (automatic enable) is 1 and the synchronized hot condition is present, throttling runs at the fixed duty AUTO_DUTY. This applies even when bit 4 is 0, and it overrides the duty set in bits 3:1.
- R5: A change of duty or of the throttle source takes effect only at the start of a modulation period, so no slot is ever shortened.
- R6: When no throttle source is active, clk_en stays high after the current period ends.
- R7: hot_n is low exactly while the temperature input, delayed by the two-flop synchronizer, is high. It changes on the second clock edge after the input changes.
- R8: irq_status bit 0 sets on a rising edge of the synchronized hot condition when control bit 6 is 1. Bit 1 sets on a falling edge when control bit 7 is 1. irq is the OR of the two status bits.
- R9: A write to address 1 clears each status bit written as 1. A set on the same edge wins over the clear.
- R10: Once the synchronized over-temperature input is seen, shutdown_n goes low and stays low until reset, whatever the control register holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 1 | 0 = control register, 1 = interrupt status (write 1 to clear) |
| wr_data | input | 8 | Write data |
| temp_hot_async | input | 1 | Thermal trip comparator output, asynchronous |
| overtemp_async | input | 1 | Catastrophic over-temperature input, asynchronous |
| clk_en | output | 1 | Core clock enable pattern |
| hot_n | output | 1 | Active-low hot indicator |
| shutdown_n | output | 1 | Active-low latched shutdown |
| irq | output | 1 | Interrupt request |
| irq_status | output | 2 | Sticky status: bit 0 = rising edge of hot, bit 1 = falling edge of hot |

## Verification
Results fall due at fixed cycle counts after each stimulus:
- **Register writes:** a write lands on its clock edge.
- **Throttling from idle:** a period begins one edge after the write edge.
- **hot_n and shutdown_n:** hot_n follows the trip input two edges later. Shutdown latches three edges after the over-temperature input.
- **Interrupt status:** a status bit sets three edges after a change of the trip input.

The bench keeps a behavioural reference model that applies these delays at every rising edge. It compares all outputs at each falling edge. Directed windows start their count exactly on the first clock of a period and count enabled clocks over one full period.

// File: rtl/thermal_throttle_pkg.sv
package thermal_throttle_pkg;

    localparam int NUM_SLOTS   = 8;
    localparam int SLOT_IDX_W  = 3;
    localparam int DUTY_W      = 3;
    localparam int SLOTS_W     = 4;
    localparam int STAT_W      = 2;

    // Control register layout, bits 7..1 of the written byte
    typedef struct packed {
        logic              ien_fall;   // bit 7
        logic              ien_rise;   // bit 6
        logic              auto_en;    // bit 5
        logic              sw_req;     // bit 4
        logic [DUTY_W-1:0] duty;       // bits 3:1
    } ctl_t;

    typedef struct packed {
        logic               active;
        logic [SLOTS_W-1:0] slots_on;
    } mod_cfg_t;

    typedef enum logic {
        ADDR_CTL  = 1'b0,
        ADDR_STAT = 1'b1
    } reg_addr_e;

    // Duty code to number of enabled slots; code 0 is reserved and means half
    function automatic logic [SLOTS_W-1:0] duty_to_slots(input logic [DUTY_W-1:0] code);
        if (code == '0)
            return SLOTS_W'(NUM_SLOTS / 2);
        else
            return {1'b0, code};
    endfunction

endpackage

// File: rtl/tt_sync.sv
module tt_sync #(
    parameter int WIDTH = 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d_async,
    output logic [WIDTH-1:0] q_sync
);
    logic [WIDTH-1:0] stage1;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage1 <= '0;
            q_sync <= '0;
        end else begin
            stage1 <= d_async;
            q_sync <= stage1;
        end
    end
endmodule

// File: rtl/tt_regs.sv
module tt_regs
    import thermal_throttle_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic              wr_addr,
    input  logic [7:0]        wr_data,
    input  logic              set_rise,
    input  logic              set_fall,
    output ctl_t              ctl,
    output logic [STAT_W-1:0] status
);
    logic [STAT_W-1:0] clr_mask;
    logic [STAT_W-1:0] set_mask;

    always_comb begin
        clr_mask = '0;
        if (wr_en && (wr_addr == ADDR_STAT))
            clr_mask = wr_data[STAT_W-1:0];
        set_mask = {set_fall & ctl.ien_fall, set_rise & ctl.ien_rise};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl    <= '0;
            status <= '0;
        end else begin
            if (wr_en && (wr_addr == ADDR_CTL))
                ctl <= ctl_t'(wr_data[7:1]);
            status <= (status & ~clr_mask) | set_mask;
        end
    end

    // R9: a cleared bit with no concurrent set reads back as zero
    assert_w1c_clear_R9: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_addr && wr_data[0] && !set_mask[0]) |=> !status[0]);

    // R9: set wins over clear
    assert_set_wins_R9: assert property (@(posedge clk) disable iff (rst)
        set_mask[1] |=> status[1]);
endmodule

// File: rtl/tt_hot_monitor.sv
module tt_hot_monitor (
    input  logic clk,
    input  logic rst,
    input  logic hot_sync,
    input  logic overtemp_sync,
    output logic hot_rise,
    output logic hot_fall,
    output logic shutdown_latched
);
    logic hot_prev;

    always_ff @(posedge clk) begin
        if (rst) begin
            hot_prev         <= 1'b0;
            shutdown_latched <= 1'b0;
        end else begin
            hot_prev         <= hot_sync;
            shutdown_latched <= shutdown_latched | overtemp_sync;
        end
    end

    always_comb begin
        hot_rise = hot_sync & ~hot_prev;
        hot_fall = ~hot_sync & hot_prev;
    end

    // R10: shutdown never releases without reset
    assert_shutdown_sticky_R10: assert property (@(posedge clk) disable iff (rst)
        shutdown_latched |=> shutdown_latched);

    // R8: edges are mutually exclusive
    assert_single_edge_R8: assert property (@(posedge clk) disable iff (rst)
        !(hot_rise && hot_fall));
endmodule

// File: rtl/tt_modulator.sv
module tt_modulator
    import thermal_throttle_pkg::*;
#(
    parameter int SLOT_CLKS = 4,
    parameter int AUTO_DUTY = 4
) (
    input  logic clk,
    input  logic rst,
    input  ctl_t ctl,
    input  logic hot_sync,
    output logic clk_en
);
    localparam int CNT_W = (SLOT_CLKS > 1) ? $clog2(SLOT_CLKS) : 1;
    localparam logic [CNT_W-1:0]      CNT_LAST  = CNT_W'(SLOT_CLKS - 1);
    localparam logic [SLOT_IDX_W-1:0] SLOT_LAST = SLOT_IDX_W'(NUM_SLOTS - 1);
    localparam logic [SLOTS_W-1:0]    AUTO_SLOTS = duty_to_slots(DUTY_W'(AUTO_DUTY));

    logic [CNT_W-1:0]      slot_cnt;
    logic [SLOT_IDX_W-1:0] slot_idx;
    mod_cfg_t              cfg;
    mod_cfg_t              cfg_next;
    logic                  auto_active;
    logic                  request;
    logic                  boundary;
    logic                  start;

    always_comb begin
        auto_active       = ctl.auto_en & hot_sync;
        request           = ctl.sw_req | auto_active;
        cfg_next.active   = request;
        cfg_next.slots_on = auto_active ? AUTO_SLOTS : duty_to_slots(ctl.duty);
        boundary          = (slot_idx == SLOT_LAST) && (slot_cnt == CNT_LAST);
        start             = boundary || (!cfg.active && request);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            slot_cnt <= '0;
            slot_idx <= '0;
            cfg      <= '0;
        end else if (start) begin
            slot_cnt <= '0;
            slot_idx <= '0;
            cfg      <= cfg_next;
        end else if (slot_cnt == CNT_LAST) begin
            slot_cnt <= '0;
            slot_idx <= slot_idx + 1'b1;
        end else begin
            slot_cnt <= slot_cnt + 1'b1;
        end
    end

    assign clk_en = !cfg.active || ({1'b0, slot_idx} < cfg.slots_on);

    // R5: configuration only moves at a period start
    assert_cfg_hold_R5: assert property (@(posedge clk) disable iff (rst)
        (cfg.active && !boundary) |=> $stable(cfg));

    // R2: a request from idle starts a fresh period on the next edge
    assert_idle_start_R2: assert property (@(posedge clk) disable iff (rst)
        (!cfg.active && request) |=> (cfg.active && slot_idx == '0 && slot_cnt == '0));

    // R4: the automatic source always loads the fixed duty
    assert_auto_duty_R4: assert property (@(posedge clk) disable iff (rst)
        (start && auto_active) |=> (cfg.slots_on == AUTO_SLOTS));
endmodule

// File: rtl/thermal_throttle_ctl.sv
module thermal_throttle_ctl
    import thermal_throttle_pkg::*;
#(
    parameter int SLOT_CLKS = 4,
    parameter int AUTO_DUTY = 4
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        wr_en,
    input  logic        wr_addr,
    input  logic [7:0]  wr_data,
    input  logic        temp_hot_async,
    input  logic        overtemp_async,
    output logic        clk_en,
    output logic        hot_n,
    output logic        shutdown_n,
    output logic        irq,
    output logic [1:0]  irq_status
);
    logic [1:0] sync_q;
    logic       hot_sync;
    logic       overtemp_sync;
    logic       hot_rise;
    logic       hot_fall;
    logic       shutdown_latched;
    ctl_t       ctl;

    tt_sync #(.WIDTH(2)) u_sync (
        .clk     (clk),
        .rst     (rst),
        .d_async ({overtemp_async, temp_hot_async}),
        .q_sync  (sync_q)
    );

    assign hot_sync      = sync_q[0];
    assign overtemp_sync = sync_q[1];

    tt_hot_monitor u_mon (
        .clk              (clk),
        .rst              (rst),
        .hot_sync         (hot_sync),
        .overtemp_sync    (overtemp_sync),
        .hot_rise         (hot_rise),
        .hot_fall         (hot_fall),
        .shutdown_latched (shutdown_latched)
    );

    tt_regs u_regs (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .set_rise (hot_rise),
        .set_fall (hot_fall),
        .ctl      (ctl),
        .status   (irq_status)
    );

    tt_modulator #(
        .SLOT_CLKS (SLOT_CLKS),
        .AUTO_DUTY (AUTO_DUTY)
    ) u_mod (
        .clk      (clk),
        .rst      (rst),
        .ctl      (ctl),
        .hot_sync (hot_sync),
        .clk_en   (clk_en)
    );

    assign hot_n      = ~hot_sync;
    assign shutdown_n = ~shutdown_latched;
    assign irq        = |irq_status;

    // R8: an enabled rising edge raises the interrupt on the next edge
    assert_rise_irq_R8: assert property (@(posedge clk) disable iff (rst)
        (hot_rise && ctl.ien_rise) |=> irq);

    // R10: the shutdown port stays low once low
    assert_shutdown_port_R10: assert property (@(posedge clk) disable iff (rst)
        !shutdown_n |=> !shutdown_n);
endmodule

// File: tb/thermal_throttle_ctl_test.sv
module thermal_throttle_ctl_test;
    localparam int CLK_PERIOD = 10;
    localparam int SC         = 4;
    localparam int AUTO       = 4;
    localparam int PER        = 8 * SC;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0;
    logic       wr_addr = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       temp = 1'b0;
    logic       ot = 1'b0;
    logic       clk_en, hot_n, shutdown_n, irq;
    logic [1:0] irq_status;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    thermal_throttle_ctl #(.SLOT_CLKS(SC), .AUTO_DUTY(AUTO)) uut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .temp_hot_async(temp), .overtemp_async(ot),
        .clk_en(clk_en), .hot_n(hot_n), .shutdown_n(shutdown_n),
        .irq(irq), .irq_status(irq_status)
    );

    // Behavioural reference model
    logic [7:0] m_ctl;
    logic [1:0] m_stat;
    logic m_s1, m_s2, m_prev, m_o1, m_o2, m_sd, m_act;
    int   m_pos, m_n;

    always @(posedge clk) begin
        logic rise, fall, auto_act, req;
        int code;
        logic [1:0] clr;
        if (rst) begin
            m_ctl = 0; m_stat = 0; m_s1 = 0; m_s2 = 0; m_prev = 0;
            m_o1 = 0; m_o2 = 0; m_sd = 0; m_act = 0; m_pos = 0; m_n = 0;
        end else begin
            rise = m_s2 && !m_prev;
            fall = !m_s2 && m_prev;
            auto_act = m_ctl[5] && m_s2;
            req = m_ctl[4] || auto_act;
            code = auto_act ? AUTO : int'(m_ctl[3:1]);
            if (m_pos == PER - 1 || (!m_act && req)) begin
                m_act = req;
                m_n = (code == 0) ? 4 : code;
                m_pos = 0;
            end else begin
                m_pos = m_pos + 1;
            end
            clr = (wr_en && wr_addr) ? wr_data[1:0] : 2'b00;
            m_stat = (m_stat & ~clr) | {fall & m_ctl[7], rise & m_ctl[6]};
            if (wr_en && !wr_addr) m_ctl = wr_data & 8'hFE;
            m_sd = m_sd | m_o2;
            m_o2 = m_o1; m_o1 = ot;
            m_prev = m_s2; m_s2 = m_s1; m_s1 = temp;
        end
    end

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (!rst) begin
            check("R3 clk_en model", {7'b0, clk_en}, {7'b0, (!m_act || (m_pos / SC) < m_n)});
            check("R7 hot_n model", {7'b0, hot_n}, {7'b0, !m_s2});
            check("R10 shutdown_n model", {7'b0, shutdown_n}, {7'b0, !m_sd});
            check("R8 irq model", {7'b0, irq}, {7'b0, |m_stat});
            check("R9 irq_status model", {6'b0, irq_status}, {6'b0, m_stat});
        end
    end

    // Watchdog
    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic wr(input logic a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic idle_wait(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // Count enabled clocks over one period starting at the edge after a write
    task automatic count_period(output int cnt);
        cnt = 0;
        for (int i = 0; i < PER; i++) begin
            @(negedge clk);
            if (clk_en) cnt++;
        end
    endtask

    initial begin
        int c;
        idle_wait(3);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check("R1 clk_en", {7'b0, clk_en}, 8'd1);
        check("R1 hot_n", {7'b0, hot_n}, 8'd1);
        check("R1 shutdown_n", {7'b0, shutdown_n}, 8'd1);
        check("R1 irq", {7'b0, irq}, 8'd0);
        check("R1 status", {6'b0, irq_status}, 8'd0);

        // R6 idle: no source, enable stays high
        c = 0;
        for (int i = 0; i < PER; i++) begin @(negedge clk); if (clk_en) c++; end
        check("R6 idle enable", 8'(c), 8'(PER));

        // R2/R3 software duty 3 (bits 3:1 = 3, bit 4 = 1)
        wr(1'b0, 8'h16);
        count_period(c);
        check("R2 R3 sw duty 3", 8'(c), 8'(3 * SC));
        wr(1'b0, 8'h00);
        idle_wait(2 * PER);

        // R3 code 0 maps to 4 slots, R2 with temp input high but no auto
        temp = 1'b1;
        wr(1'b0, 8'h10);
        count_period(c);
        check("R3 code0 half", 8'(c), 8'(4 * SC));
        wr(1'b0, 8'h00);
        idle_wait(2 * PER);

        // R4 automatic only: hot present, auto_en set, duty field 7 ignored
        wr(1'b0, 8'h2E);
        count_period(c);
        check("R4 auto only", 8'(c), 8'(AUTO * SC));
        wr(1'b0, 8'h00);
        idle_wait(2 * PER);

        // R4 override: sw duty 7 with auto and hot
        wr(1'b0, 8'h3E);
        count_period(c);
        check("R4 auto overrides sw", 8'(c), 8'(AUTO * SC));
        wr(1'b0, 8'h00);
        idle_wait(2 * PER);
        temp = 1'b0;
        idle_wait(4);

        // R5 mid-period duty change waits for boundary
        wr(1'b0, 8'h14);
        c = 0;
        for (int i = 0; i < PER; i++) begin
            @(negedge clk);
            if (clk_en) c++;
            if (i == 10) begin wr_en = 1'b1; wr_addr = 1'b0; wr_data = 8'h1C; end
            if (i == 11) wr_en = 1'b0;
        end
        check("R5 current period kept", 8'(c), 8'(2 * SC));
        c = 0;
        for (int i = 0; i < PER; i++) begin @(negedge clk); if (clk_en) c++; end
        check("R5 new duty next period", 8'(c), 8'(6 * SC));
        wr(1'b0, 8'h00);
        idle_wait(2 * PER);
        c = 0;
        for (int i = 0; i < PER; i++) begin @(negedge clk); if (clk_en) c++; end
        check("R6 back to idle", 8'(c), 8'(PER));

        // R7 / R8 / R9 interrupts on both edges
        wr(1'b0, 8'hC0);
        temp = 1'b1;
        @(negedge clk);
        check("R7 hot_n not yet", {7'b0, hot_n}, 8'd1);
        @(negedge clk);
        check("R7 hot_n low after two edges", {7'b0, hot_n}, 8'd0);
        @(negedge clk);
        check("R8 rise status", {6'b0, irq_status}, 8'd1);
        check("R8 irq", {7'b0, irq}, 8'd1);
        wr(1'b1, 8'h01);
        check("R9 w1c clears", {6'b0, irq_status}, 8'd0);
        temp = 1'b0;
        idle_wait(3);
        check("R8 fall status", {6'b0, irq_status}, 8'd2);
        wr(1'b1, 8'h01);
        check("R9 w1c other bit kept", {6'b0, irq_status}, 8'd2);
        wr(1'b1, 8'h02);
        check("R9 cleared", {7'b0, irq}, 8'd0);

        // R10 shutdown latch
        ot = 1'b1;
        idle_wait(4);
        ot = 1'b0;
        wr(1'b0, 8'h00);
        idle_wait(20);
        check("R10 shutdown held", {7'b0, shutdown_n}, 8'd0);
        @(negedge clk); rst = 1'b1;
        idle_wait(3);
        rst = 1'b0;
        @(negedge clk);
        check("R10 released by reset", {7'b0, shutdown_n}, 8'd1);
        idle_wait(4);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule